// File: doc/BRIEF.md
# Backplane Bus Handover Controller

This block decides when the permanent bus master hands the shared backplane to a temporary master, such as a DMA disk controller or a second processor. A temporary master pulls the active-low hold request and keeps it low until it is finished, or until it learns that it will not be granted. The controller waits for a cycle boundary on the permanent master. It then raises hold acknowledge and four float enables, one each for the address drivers, the data-out drivers, the status drivers and the control drivers. When hold is released, the float enables drop first. Hold acknowledge follows one clock later, and at that point the permanent master may drive again.

While the request waits, the controller records the identity code carried on four active-low priority lines. The highest code seen wins, and it stays frozen for as long as the bus is handed over. The permanent master can mask hold requests at any time. The memory-write strobe is formed here from the write strobe and the output-cycle status. It never depends on the control float, so memory stays writable by whichever master owns the bus.

All pins are plain level signals with no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_handover`

## Requirements
- R1: After reset, hold_ack, all four float outputs and winner_id are 0.
- R2: At a rising clock edge where hold_req_n is 0, hold_mask is 0 and pm_cycle_busy is 0, and no handover is in progress, hold_ack and all four float outputs become 1 after that edge.
- R3: No handover starts at an edge where pm_cycle_busy is 1. The grant happens at the first edge where it is 0 and the request is still present.
- R4: No handover starts while hold_mask is 1. If hold_mask becomes 1 during a handover, release starts exactly as if hold_req_n had gone high.
- R5: Release has two steps. At the edge where the request is gone, all float outputs fall and hold_ack stays 1. At the next edge hold_ack falls.
- R6: While a request waits, winner_id holds the running maximum of the bitwise-inverted prio_req_n values sampled at each edge, including the grant edge. It stays constant throughout the handover and reads 0 once release begins or the request is withdrawn before a grant.
- R7: mem_write is 1 exactly when pm_wr_strobe is 1 and pm_out_cycle is 0, whatever the float outputs are doing.
- R8: If hold_req_n goes low again during the release step, the controller still goes idle first. A new grant needs a further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master clock |
| rst_n | input | 1 | Active-low reset |
| hold_req_n | input | 1 | Active-low hold request from a temporary master |
| hold_mask | input | 1 | Permanent master blocks or revokes hold |
| pm_cycle_busy | input | 1 | Permanent master is inside a bus cycle or strobe |
| prio_req_n | input | 4 | Active-low identity code of the requester |
| pm_wr_strobe | input | 1 | Generalized write strobe, active high |
| pm_out_cycle | input | 1 | Output (I/O write) cycle status |
| hold_ack | output | 1 | Permanent master has given up the bus |
| addr_float | output | 1 | Float the address drivers |
| dout_float | output | 1 | Float the data-out drivers |
| stat_float | output | 1 | Float the status drivers |
| ctrl_float | output | 1 | Float the control drivers (not memory write) |
| winner_id | output | 4 | Latched code of the winning requester |
| mem_write | output | 1 | Memory write strobe |

## Verification
Grant and release take effect in the cycle that follows the deciding clock edge, because one register stands between the inputs and each output. The one exception is the second release step, where hold_ack drops one edge later than the floats. mem_write is combinational, so it is checked one nanosecond after its inputs change. The driver applies inputs on the falling edge and queues the output state that is due after the next rising edge. The monitor compares each queued item five nanoseconds after that rising edge.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_OWNED  = 2'd1,
    HS_RETURN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/handover_fsm.sv
module handover_fsm
  import bus_handover_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want,
  input  logic      busy,
  output hs_state_e state_q,
  output hs_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:   if (want && !busy) state_d = HS_OWNED;
      HS_OWNED:  if (!want)         state_d = HS_RETURN;
      HS_RETURN:                    state_d = HS_IDLE;
      default:                      state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;

  // R5
  return_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RETURN) |=> (state_q == HS_IDLE));
  // R8
  no_direct_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RETURN) |=> (state_q != HS_OWNED));
endmodule

// File: rtl/prio_winner.sv
module prio_winner #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              frozen,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] win_q
);
  logic [CODE_W-1:0] win_d;

  always_comb begin
    if (frozen)       win_d = win_q;
    else if (pending) win_d = (code > win_q) ? code : win_q;
    else              win_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;

  // R6
  winner_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(win_q));
endmodule

// File: rtl/float_bank.sv
module float_bank #(
  parameter int N_GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_d,
  output logic [N_GRP-1:0] float_q
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) float_q[g] <= 1'b0;
      else        float_q[g] <= en_d;
  end
endmodule

// File: rtl/bus_handover.sv
module bus_handover
  import bus_handover_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req_n,
  input  logic              hold_mask,
  input  logic              pm_cycle_busy,
  input  logic [CODE_W-1:0] prio_req_n,
  input  logic              pm_wr_strobe,
  input  logic              pm_out_cycle,
  output logic              hold_ack,
  output logic              addr_float,
  output logic              dout_float,
  output logic              stat_float,
  output logic              ctrl_float,
  output logic [CODE_W-1:0] winner_id,
  output logic              mem_write
);
  localparam int N_GRP = 4;

  hs_state_e        state_q, state_d;
  logic             want;
  logic [N_GRP-1:0] fl_q;

  assign want = !hold_req_n && !hold_mask;

  handover_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .want(want), .busy(pm_cycle_busy),
    .state_q(state_q), .state_d(state_d)
  );

  prio_winner #(.CODE_W(CODE_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .pending(state_q == HS_IDLE && !hold_req_n),
    .frozen(state_q == HS_OWNED && state_d == HS_OWNED),
    .code(~prio_req_n), .win_q(winner_id)
  );

  float_bank #(.N_GRP(N_GRP)) u_fl (
    .clk(clk), .rst_n(rst_n), .en_d(state_d == HS_OWNED), .float_q(fl_q)
  );

  assign addr_float = fl_q[0];
  assign dout_float = fl_q[1];
  assign stat_float = fl_q[2];
  assign ctrl_float = fl_q[3];
  assign hold_ack   = (state_q != HS_IDLE);
  assign mem_write  = pm_wr_strobe && !pm_out_cycle;

  // R2 R3 R4
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!hold_req_n && !hold_mask && !pm_cycle_busy));
  // R5
  float_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_float || dout_float || stat_float || ctrl_float) |-> hold_ack);
  // R5
  ack_drops_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> $past(!addr_float && !ctrl_float));
  // R2
  groups_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_float == ctrl_float) && (dout_float == stat_float) && (addr_float == dout_float));
endmodule

// File: tb/bus_handover_tb_top.sv
module bus_handover_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1, hold_mask = 1'b0, pm_cycle_busy = 1'b0;
  logic [3:0] prio_req_n = 4'hF;
  logic pm_wr_strobe = 1'b0, pm_out_cycle = 1'b0;
  logic hold_ack, addr_float, dout_float, stat_float, ctrl_float, mem_write;
  logic [3:0] winner_id;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic ack; logic [3:0] fl; logic [3:0] id; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  bus_handover dut_i (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_mask(hold_mask),
    .pm_cycle_busy(pm_cycle_busy), .prio_req_n(prio_req_n),
    .pm_wr_strobe(pm_wr_strobe), .pm_out_cycle(pm_out_cycle),
    .hold_ack(hold_ack), .addr_float(addr_float), .dout_float(dout_float),
    .stat_float(stat_float), .ctrl_float(ctrl_float),
    .winner_id(winner_id), .mem_write(mem_write)
  );

  function automatic logic [3:0] fl_now();
    return {ctrl_float, stat_float, dout_float, addr_float};
  endfunction

  task automatic step(input logic hn, input logic mk, input logic bz, input logic [3:0] code,
                      input logic e_ack, input logic [3:0] e_fl, input logic [3:0] e_id,
                      input string tag);
    exp_t e;
    @(negedge clk);
    hold_req_n = hn; hold_mask = mk; pm_cycle_busy = bz; prio_req_n = ~code;
    e.ack = e_ack; e.fl = e_fl; e.id = e_id; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic check_mw(input logic wr, input logic oc, input logic e_mw);
    pm_wr_strobe = wr; pm_out_cycle = oc;
    #1;
    total++;
    if (mem_write !== e_mw) begin
      bad++;
      $display("FAIL R7 mem_write actual=%b expected=%b", mem_write, e_mw);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (hold_ack !== e.ack || fl_now() !== e.fl || winner_id !== e.id) begin
          bad++;
          $display("FAIL %s actual ack=%b fl=%h id=%h expected ack=%b fl=%h id=%h",
                   e.tag, hold_ack, fl_now(), winner_id, e.ack, e.fl, e.id);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    total++;
    if (hold_ack !== 1'b0 || fl_now() !== 4'h0 || winner_id !== 4'h0) begin
      bad++;
      $display("FAIL R1 actual ack=%b fl=%h id=%h expected 0 0 0", hold_ack, fl_now(), winner_id);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 0, 4'h0, 0, 4'h0, 4'h0, "R1 idle");
    // R3: busy defers grant, R6 running max accumulates
    step(0, 0, 1, 4'h3, 0, 4'h0, 4'h3, "R3 busy wait");
    step(0, 0, 1, 4'h9, 0, 4'h0, 4'h9, "R6 max while pending");
    // R2 grant at boundary
    step(0, 0, 0, 4'h5, 1, 4'hF, 4'h9, "R2 grant");
    step(0, 0, 0, 4'hF, 1, 4'hF, 4'h9, "R6 frozen");
    check_mw(1, 0, 1);
    check_mw(1, 1, 0);
    check_mw(0, 0, 0);
    // R5 two-step release
    step(1, 0, 0, 4'h0, 1, 4'h0, 4'h0, "R5 floats drop");
    step(1, 0, 0, 4'h0, 0, 4'h0, 4'h0, "R5 ack drops");
    // R4 mask blocks then revokes
    step(0, 1, 0, 4'h2, 0, 4'h0, 4'h2, "R4 masked");
    step(0, 0, 0, 4'h2, 1, 4'hF, 4'h2, "R4 unmask grant");
    step(0, 1, 0, 4'h2, 1, 4'h0, 4'h0, "R4 mask revokes");
    // R8 reassert during release
    step(0, 0, 0, 4'h7, 0, 4'h0, 4'h0, "R8 idle first");
    step(0, 0, 0, 4'h7, 1, 4'hF, 4'h7, "R8 regrant");
    step(1, 0, 0, 4'h0, 1, 4'h0, 4'h0, "R5 release again");
    step(1, 0, 0, 4'h0, 0, 4'h0, 4'h0, "R5 idle again");
    // R6 withdrawn before grant clears winner
    step(0, 0, 1, 4'h6, 0, 4'h0, 4'h6, "R6 pending");
    step(1, 0, 1, 4'h6, 0, 4'h0, 4'h0, "R6 withdrawn");
    step(1, 0, 0, 4'h0, 0, 4'h0, 4'h0, "R3 no grant");
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule